// File: doc/BRIEF.md
# Prefix-Tracking Instruction Front End

This block sits at the head of a byte-coded 16-bit processor core. It holds a single-byte prefetch pipe that is filled from program memory at the current program counter, and it hands each non-prefix byte to the execute stage as a 10-bit dispatch index. Two mode bits are folded into the top of that index, so the execute stage sees four separate opcode maps.

Prefix bytes never leave the block. One class of prefix sets one or both mode bits. Another class sets the source register, the destination register, or both; the "both" form also raises a register-prefix flag. When the execute stage accepts a non-prefix byte, all prefix state returns to its idle value. Each step consumes the pipe byte and refills the pipe in the same cycle. Because of this, the byte that follows a branch has already been fetched when the branch issues, and it executes before the branch target. A run-enable input freezes the whole front end.

Program bytes arrive on a valid/ready fetch port. A transfer on that port means the program counter advances by one. Dispatches leave on a valid/ready port. While `disp_ready` is low, `disp_valid` stays high, `disp_index` stays unchanged, and no byte is fetched. The fetch side may drop `fetch_valid` at any time. The pipe then empties and is refilled later from the same address.

Top module: `ipd_dispatch_front`

## Requirements
- R1: After reset the pipe is empty. Both mode bits and the register-prefix flag are 0, both selects are 0, and `disp_index` reads 0.
- R2: While `go` is 0, `fetch_ready` and `disp_valid` are 0, and the pipe byte and all prefix state keep their values.
- R3: With `go` at 1 and the pipe empty, `fetch_ready` is 1 and `disp_valid` is 0. The first byte is executed only after it has been loaded into the pipe.
- R4: `disp_index` is {mode2, mode1, pipe byte}. Mode 0 gives 0x0xx, mode1 only gives 0x1xx, mode2 only gives 0x2xx, and both give 0x3xx.
- R5: In a cycle where the pipe byte is consumed, the block asserts `fetch_ready`. If `fetch_valid` is 1, `fetch_data` becomes the new pipe byte and `pc_inc` is 1.
- R6: While `disp_valid` is 1 and `disp_ready` is 0, the block holds `disp_index`, fetches nothing, and keeps `disp_valid` at 1 as long as `go` stays 1.
- R7: Byte 0x3D sets mode1, byte 0x3E sets mode2, and byte 0x3F sets both. Each takes one cycle, leaves the other mode bit unchanged, and is never dispatched.
- R8: Byte 0x1n sets the destination select to n, and byte 0xBn sets the source select to n. Byte 0x2n sets both selects to n and sets the register-prefix flag. None of these bytes is dispatched.
- R9: In the cycle after a non-prefix byte is accepted, both mode bits, the register-prefix flag and both selects are 0.
- R10: If the pipe is consumed while `fetch_valid` is 0, the pipe becomes empty. `disp_valid` then stays 0 until a fetch transfer refills it.
- R11: The next byte executed after any dispatched byte is the one fetched in that dispatch's cycle, even if the program counter is redirected afterwards. This is the delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Core run enable |
| fetch_valid | input | 1 | Program byte on `fetch_data` is valid |
| fetch_data | input | 8 | Program byte at the current program counter |
| fetch_ready | output | 1 | Block takes a program byte this cycle |
| pc_inc | output | 1 | Fetch transfer; program counter advances |
| disp_valid | output | 1 | A non-prefix byte is offered to the execute stage |
| disp_ready | input | 1 | Execute stage accepts the offered byte |
| disp_index | output | 10 | {mode2, mode1, opcode} dispatch index |
| src_sel | output | 4 | Current source register select |
| dst_sel | output | 4 | Current destination register select |
| with_flag | output | 1 | Register-prefix flag |

## Verification
A behavioural model runs alongside the block and is compared with it on every cycle. The stimulus includes:
- runs of plain opcodes, which separate a correct refill from a stale or doubled pipe byte;
- each mode prefix alone and in combination, which shows whether the index bits are swapped or fail to accumulate;
- each register-prefix form, which shows whether source and destination are mixed up;
- stalls on both ports and a pause of `go`, which test that state is held.

A short program with a redirected counter checks the delay slot: the byte after the branch must issue before the target.

// File: rtl/ipd_pkg.sv
package ipd_pkg;
  localparam int OPC_W = 8;
  localparam int SEL_W = 4;
  localparam int GRP_W = OPC_W - SEL_W;

  localparam logic [OPC_W-1:0] OPC_MODE1 = 8'h3D;
  localparam logic [OPC_W-1:0] OPC_MODE2 = 8'h3E;
  localparam logic [OPC_W-1:0] OPC_MODE3 = 8'h3F;
  localparam logic [GRP_W-1:0] GRP_DST   = 4'h1;
  localparam logic [GRP_W-1:0] GRP_BOTH  = 4'h2;
  localparam logic [GRP_W-1:0] GRP_SRC   = 4'hB;

  typedef enum logic [2:0] {
    PK_NONE, PK_MODE1, PK_MODE2, PK_MODE3, PK_DST, PK_SRC, PK_BOTH
  } pfx_kind_e;
endpackage

// File: rtl/ipd_pipe.sv
module ipd_pipe #(
  parameter int OP_W = ipd_pkg::OPC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            load_valid,
  input  logic [OP_W-1:0] load_data,
  output logic            full,
  output logic [OP_W-1:0] byte_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full   <= 1'b0;
      byte_q <= '0;
    end else if (load) begin
      full <= load_valid;
      if (load_valid) byte_q <= load_data;
    end
  end
endmodule

// File: rtl/ipd_pfx_decode.sv
module ipd_pfx_decode
  import ipd_pkg::*;
#(
  parameter int OP_W = OPC_W,
  parameter int S_W  = SEL_W
) (
  input  logic [OP_W-1:0] op,
  output pfx_kind_e       kind,
  output logic [S_W-1:0]  reg_num
);
  localparam int G_W = OP_W - S_W;
  logic [G_W-1:0] grp;

  assign grp     = op[OP_W-1:S_W];
  assign reg_num = op[S_W-1:0];

  always_comb begin
    kind = PK_NONE;
    if (op == OPC_MODE1)      kind = PK_MODE1;
    else if (op == OPC_MODE2) kind = PK_MODE2;
    else if (op == OPC_MODE3) kind = PK_MODE3;
    else if (grp == GRP_DST)  kind = PK_DST;
    else if (grp == GRP_SRC)  kind = PK_SRC;
    else if (grp == GRP_BOTH) kind = PK_BOTH;
  end
endmodule

// File: rtl/ipd_pfx_state.sv
module ipd_pfx_state
  import ipd_pkg::*;
#(
  parameter int S_W = SEL_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pfx_fire,
  input  logic           clear,
  input  pfx_kind_e      kind,
  input  logic [S_W-1:0] reg_num,
  output logic           mode1,
  output logic           mode2,
  output logic           bflag,
  output logic [S_W-1:0] src,
  output logic [S_W-1:0] dst
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      mode1 <= 1'b0;
      mode2 <= 1'b0;
      bflag <= 1'b0;
      src   <= '0;
      dst   <= '0;
    end else if (pfx_fire) begin
      case (kind)
        PK_MODE1: mode1 <= 1'b1;
        PK_MODE2: mode2 <= 1'b1;
        PK_MODE3: begin mode1 <= 1'b1; mode2 <= 1'b1; end
        PK_DST:   dst <= reg_num;
        PK_SRC:   src <= reg_num;
        PK_BOTH:  begin src <= reg_num; dst <= reg_num; bflag <= 1'b1; end
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/ipd_dispatch_front.sv
module ipd_dispatch_front
  import ipd_pkg::*;
#(
  parameter int OP_W = OPC_W,
  parameter int S_W  = SEL_W,
  localparam int IDX_W = OP_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             fetch_valid,
  input  logic [OP_W-1:0]  fetch_data,
  output logic             fetch_ready,
  output logic             pc_inc,
  output logic             disp_valid,
  input  logic             disp_ready,
  output logic [IDX_W-1:0] disp_index,
  output logic [S_W-1:0]   src_sel,
  output logic [S_W-1:0]   dst_sel,
  output logic             with_flag
);
  logic            pipe_full;
  logic [OP_W-1:0] pipe_byte;
  pfx_kind_e       kind;
  logic [S_W-1:0]  reg_num;
  logic            is_pfx, step, mode1, mode2;

  assign is_pfx      = (kind != PK_NONE);
  assign step        = go && pipe_full && (is_pfx || disp_ready);
  assign disp_valid  = go && pipe_full && !is_pfx;
  assign fetch_ready = go && (!pipe_full || step);
  assign pc_inc      = fetch_ready && fetch_valid;
  assign disp_index  = {mode2, mode1, pipe_byte};

  ipd_pipe #(.OP_W(OP_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .load(fetch_ready), .load_valid(fetch_valid),
    .load_data(fetch_data), .full(pipe_full), .byte_q(pipe_byte)
  );

  ipd_pfx_decode #(.OP_W(OP_W), .S_W(S_W)) u_dec (
    .op(pipe_byte), .kind(kind), .reg_num(reg_num)
  );

  ipd_pfx_state #(.S_W(S_W)) u_state (
    .clk(clk), .rst_n(rst_n), .pfx_fire(step && is_pfx),
    .clear(step && !is_pfx), .kind(kind), .reg_num(reg_num),
    .mode1(mode1), .mode2(mode2), .bflag(with_flag),
    .src(src_sel), .dst(dst_sel)
  );
endmodule

// File: rtl/ipd_dispatch_front_chk.sv
module ipd_dispatch_front_chk
  import ipd_pkg::*;
#(
  parameter int OP_W = OPC_W,
  parameter int S_W  = SEL_W,
  localparam int IDX_W = OP_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic             fetch_ready,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [IDX_W-1:0] disp_index,
  input logic [S_W-1:0]   src_sel,
  input logic [S_W-1:0]   dst_sel,
  input logic             with_flag
);
  logic [OP_W-1:0] opc;
  assign opc = disp_index[OP_W-1:0];

  // R2
  idle_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> (!fetch_ready && !disp_valid));

  // R6
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> $stable(disp_index));

  // R6
  no_fetch_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |-> !fetch_ready);

  // R9
  clear_after_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=>
      (!with_flag && src_sel == '0 && dst_sel == '0 && disp_index[IDX_W-1 -: 2] == 2'b00));

  // R7
  prefix_not_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (opc != OPC_MODE1 && opc != OPC_MODE2 && opc != OPC_MODE3 &&
                    opc[OP_W-1:S_W] != GRP_DST && opc[OP_W-1:S_W] != GRP_SRC &&
                    opc[OP_W-1:S_W] != GRP_BOTH));
endmodule

bind ipd_dispatch_front ipd_dispatch_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .fetch_ready(fetch_ready),
  .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_index(disp_index),
  .src_sel(src_sel), .dst_sel(dst_sel), .with_flag(with_flag)
);

// File: tb/ipd_dispatch_front_tb.sv
module ipd_dispatch_front_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, go, fetch_valid, disp_ready;
  logic [7:0] fetch_data;
  logic fetch_ready, pc_inc, disp_valid, with_flag;
  logic [9:0] disp_index;
  logic [3:0] src_sel, dst_sel;

  int n_cmp = 0, n_bad = 0;

  // reference model state
  bit m_full, m_a1, m_a2, m_b;
  bit [7:0] m_pipe;
  bit [3:0] m_src, m_dst;
  bit last_pc, last_dv;
  bit [9:0] last_idx;

  always #(CLK_P/2) clk = ~clk;

  ipd_dispatch_front dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .fetch_valid(fetch_valid),
    .fetch_data(fetch_data), .fetch_ready(fetch_ready), .pc_inc(pc_inc),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_index(disp_index),
    .src_sel(src_sel), .dst_sel(dst_sel), .with_flag(with_flag)
  );

  function automatic bit m_is_pfx(bit [7:0] b);
    return b == 8'h3D || b == 8'h3E || b == 8'h3F ||
           b[7:4] == 4'h1 || b[7:4] == 4'h2 || b[7:4] == 4'hB;
  endfunction

  task automatic chk(string tag, string sig, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, sig, act, exp);
    end
  endtask

  task automatic model_reset();
    m_full = 0; m_pipe = 0; m_a1 = 0; m_a2 = 0; m_b = 0; m_src = 0; m_dst = 0;
  endtask

  // drive one cycle, compare all outputs against the model, advance the model
  task automatic cyc(bit g, bit fv, bit [7:0] fd, bit rdy, string tag);
    bit pf, dv, st, fr;
    @(negedge clk);
    go = g; fetch_valid = fv; fetch_data = fd; disp_ready = rdy;
    #1;
    pf = m_is_pfx(m_pipe);
    dv = g && m_full && !pf;
    st = g && m_full && (pf || rdy);
    fr = g && (!m_full || st);
    chk(tag, "disp_valid", disp_valid, dv);
    chk(tag, "fetch_ready", fetch_ready, fr);
    chk(tag, "pc_inc", pc_inc, fr && fv);
    chk(tag, "disp_index", disp_index, {m_a2, m_a1, m_pipe});
    chk(tag, "src_sel", src_sel, m_src);
    chk(tag, "dst_sel", dst_sel, m_dst);
    chk(tag, "with_flag", with_flag, m_b);
    last_pc = pc_inc; last_dv = disp_valid && rdy; last_idx = disp_index;
    @(posedge clk);
    if (st) begin
      if (!pf) begin
        m_a1 = 0; m_a2 = 0; m_b = 0; m_src = 0; m_dst = 0;
      end else if (m_pipe == 8'h3D) m_a1 = 1;
      else if (m_pipe == 8'h3E) m_a2 = 1;
      else if (m_pipe == 8'h3F) begin m_a1 = 1; m_a2 = 1; end
      else if (m_pipe[7:4] == 4'h1) m_dst = m_pipe[3:0];
      else if (m_pipe[7:4] == 4'hB) m_src = m_pipe[3:0];
      else begin m_src = m_pipe[3:0]; m_dst = m_pipe[3:0]; m_b = 1; end
    end
    if (fr) begin
      m_full = fv;
      if (fv) m_pipe = fd;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; go = 0; fetch_valid = 0; fetch_data = 0; disp_ready = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    #(CLK_P * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit [7:0] mem [16];
    bit [7:0] got [$];
    bit [7:0] want [5] = '{8'h01, 8'h05, 8'h06, 8'h60, 8'h61};
    int pc;
    do_reset();
    // R1 reset state, go low
    cyc(0, 1, 8'hAA, 1, "R1");
    cyc(0, 1, 8'hAA, 1, "R2");
    // R3 start: first cycle only loads
    cyc(1, 1, 8'h55, 1, "R3");
    // R5 plain stream, R4 mode 0
    cyc(1, 1, 8'h41, 1, "R5");
    cyc(1, 1, 8'h42, 1, "R5");
    cyc(1, 1, 8'h43, 1, "R4");
    // R6 stall
    cyc(1, 1, 8'h90, 0, "R6");
    cyc(1, 1, 8'h91, 0, "R6");
    cyc(1, 1, 8'h3D, 1, "R6");
    // R7 mode prefixes: 3D,40 ; 3E,40 ; 3F,40 ; 3D,3E,40
    cyc(1, 1, 8'h40, 1, "R7");
    cyc(1, 1, 8'h3E, 1, "R4");
    cyc(1, 1, 8'h40, 1, "R7");
    cyc(1, 1, 8'h3F, 1, "R4");
    cyc(1, 1, 8'h40, 1, "R7");
    cyc(1, 1, 8'h3D, 1, "R4");
    cyc(1, 1, 8'h3E, 1, "R7");
    cyc(1, 1, 8'h40, 1, "R7");
    cyc(1, 1, 8'h13, 0, "R4");
    // R8 register selects, R9 clear after issue
    cyc(1, 1, 8'hB5, 1, "R8");
    cyc(1, 1, 8'h44, 1, "R8");
    cyc(1, 1, 8'h27, 1, "R8");
    cyc(1, 1, 8'h45, 1, "R8");
    cyc(1, 1, 8'h46, 0, "R9");
    cyc(1, 1, 8'h46, 1, "R9");
    // R10 fetch not valid during consume
    cyc(1, 0, 8'h00, 1, "R10");
    cyc(1, 0, 8'h00, 1, "R10");
    cyc(1, 1, 8'h47, 1, "R10");
    // R2 pause with full pipe and pending prefix
    cyc(1, 1, 8'h3E, 1, "R2");
    cyc(1, 1, 8'h48, 1, "R2");
    cyc(0, 1, 8'hEE, 1, "R2");
    cyc(0, 1, 8'hEE, 1, "R2");
    cyc(1, 1, 8'h49, 1, "R2");
    cyc(1, 1, 8'h4A, 1, "R2");
    // R11 delay slot with redirected counter
    do_reset();
    foreach (mem[i]) mem[i] = 8'h70 + 8'(i);
    mem[0] = 8'h01; mem[1] = 8'h05; mem[2] = 8'h06; mem[3] = 8'h07;
    mem[8] = 8'h60; mem[9] = 8'h61;
    pc = 0;
    for (int k = 0; k < 6; k++) begin
      cyc(1, 1, mem[pc], 1, "R11");
      if (last_pc) pc++;
      if (last_dv) begin
        got.push_back(last_idx[7:0]);
        if (last_idx[7:0] == 8'h05) pc = 8;
      end
    end
    chk("R11", "issue count", got.size(), 5);
    for (int k = 0; k < 5 && k < got.size(); k++)
      chk("R11", "issue order", got[k], want[k]);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule